// File: doc/BRIEF.md
# Converter Self-Calibration Sequencer

This block sits on the host side of a pipelined data converter that calibrates itself on demand. A software request starts a calibration: the sequencer drives a start pulse of programmable length toward the converter. It then watches the converter's ready line, which has no relation to the local clock. The line must drop shortly after the pulse begins and come back high once the converter has finished. Both phases have a time limit. A missing drop or a missing return ends the attempt with a distinct error flag.

While an attempt is in flight the sequencer reports busy and withholds the enable of the downstream capture logic. A successful return produces a single-cycle done pulse. A separate flag asks for a new calibration when an external temperature-drift indication is raised. The flag stays set until a calibration completes.

Top module: `cal_seq_ctrl`

## Requirements
- R1: After reset, cal_start_o, busy_o, done_o, err_noresp_o, err_timeout_o and recal_o are 0 and capture_en_o is 1.
- R2: An accepted request produces a start pulse whose length in cycles is pulse_len_i clamped into the range 4 to 1024. The length is sampled in the request cycle.
- R3: eoc_ready_i passes through a two-flop synchronizer. A drop that is applied no later than 5 cycles after the first high cycle of the start pulse is accepted. A drop applied 6 cycles after that cycle is too late.
- R4: If no synchronized drop is seen within 8 cycles of the pulse start, err_noresp_o is set and the sequencer returns to idle. A pulse that is still running is cut off, so at most 8 high cycles are produced.
- R5: A synchronized rise after the drop ends the attempt. done_o is high for exactly one cycle, in the same cycle busy_o goes low.
- R6: If the rise is not seen within 20,000 cycles of the detected drop, err_timeout_o is set, the sequencer returns to idle and done_o stays low.
- R7: Each error flag stays set until the next accepted request, which clears both flags.
- R8: A request while busy_o is high is ignored. It does not restart or lengthen the pulse and does not add a done pulse.
- R9: busy_o is high from the cycle after an accepted request until the attempt ends. capture_en_o is always the inverse of busy_o, and cal_start_o is never high while busy_o is low.
- R10: recal_o is set in the cycle after drift_i is high. It is cleared when an attempt completes with done, unless drift_i is high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, runs continuously |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cal_req_i | input | 1 | Software request to calibrate |
| pulse_len_i | input | 11 | Requested start pulse length in cycles |
| eoc_ready_i | input | 1 | Converter ready line, asynchronous; low while calibrating |
| drift_i | input | 1 | Temperature drift indication |
| cal_start_o | output | 1 | Start pulse to the converter |
| busy_o | output | 1 | Calibration attempt in flight |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_noresp_o | output | 1 | Ready line did not drop in time |
| err_timeout_o | output | 1 | Ready line did not return in time |
| recal_o | output | 1 | Recalibration recommended |
| capture_en_o | output | 1 | Enable for the capture block |

## Verification
The hardest cases to reach are the edges of the response window. The sequencer only ever sees the synchronized copy of the ready line, so whether a drop counts depends on where it falls relative to the two synchronizer flops. The bench contains a converter model that drops the line a programmable number of cycles after it first sees the pulse. Running that model at 5 and at 6 cycles reaches both sides of the window. A model that never raises the line drives the sequencer into the long timeout path. A model that never drops it, given a long requested pulse, shows the pulse being cut short.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FALL = 2'd1,
    ST_RISE = 2'd2
  } cal_st_e;
endpackage

// File: rtl/cal_sync.sv
module cal_sync #(
  parameter int          STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/cal_pulse_gen.sv
module cal_pulse_gen #(
  parameter int MIN_W = 4,
  parameter int MAX_W = 1024,
  localparam int WW = $clog2(MAX_W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          abort_i,
  input  logic [WW-1:0] len_i,
  output logic          pulse_o
);
  localparam logic [WW-1:0] MinL = WW'(MIN_W);
  localparam logic [WW-1:0] MaxL = WW'(MAX_W);

  logic [WW-1:0] len_c;
  logic [WW-1:0] cnt_q;
  logic          on_q;

  always_comb begin
    if (len_i < MinL)      len_c = MinL;
    else if (len_i > MaxL) len_c = MaxL;
    else                   len_c = len_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q  <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      on_q  <= 1'b1;
      cnt_q <= len_c;
    end else if (abort_i) begin
      on_q  <= 1'b0;
      cnt_q <= '0;
    end else if (on_q) begin
      if (cnt_q == WW'(1)) on_q <= 1'b0;
      cnt_q <= cnt_q - WW'(1);
    end
  end

  assign pulse_o = on_q;

  // R2: remaining count stays in range while the pulse runs
  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_q |-> (cnt_q != '0) && (cnt_q <= MaxL));

  // R2: a load always starts at least the minimum length
  p_load_min_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (on_q && cnt_q >= MinL));
endmodule

// File: rtl/cal_fsm.sv
module cal_fsm
  import cal_seq_pkg::*;
#(
  parameter int RESP_WIN = 8,
  parameter int DONE_TMO = 20000,
  localparam int TW = $clog2(DONE_TMO + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic rdy_s_i,
  input  logic drift_i,
  output logic load_o,
  output logic abort_o,
  output logic busy_o,
  output logic done_o,
  output logic err_noresp_o,
  output logic err_timeout_o,
  output logic recal_o
);
  cal_st_e       st_q;
  logic [TW-1:0] tcnt_q;
  logic          done_q, enr_q, eto_q, recal_q;
  logic          fin_ok, fin_nr, fin_to;

  assign load_o = (st_q == ST_IDLE) && req_i;
  assign fin_nr = (st_q == ST_FALL) && rdy_s_i && (tcnt_q == TW'(RESP_WIN - 1));
  assign fin_ok = (st_q == ST_RISE) && rdy_s_i;
  assign fin_to = (st_q == ST_RISE) && !rdy_s_i && (tcnt_q == TW'(DONE_TMO - 1));
  assign abort_o = fin_nr || fin_ok || fin_to;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tcnt_q <= '0;
      done_q <= 1'b0;
      enr_q  <= 1'b0;
      eto_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          st_q   <= ST_FALL;
          tcnt_q <= '0;
          enr_q  <= 1'b0;
          eto_q  <= 1'b0;
        end
        ST_FALL: begin
          if (!rdy_s_i) begin
            st_q   <= ST_RISE;
            tcnt_q <= '0;
          end else if (fin_nr) begin
            st_q  <= ST_IDLE;
            enr_q <= 1'b1;
          end else begin
            tcnt_q <= tcnt_q + TW'(1);
          end
        end
        ST_RISE: begin
          if (fin_ok) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else if (fin_to) begin
            st_q  <= ST_IDLE;
            eto_q <= 1'b1;
          end else begin
            tcnt_q <= tcnt_q + TW'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      recal_q <= 1'b0;
    else if (drift_i) recal_q <= 1'b1;
    else if (fin_ok)  recal_q <= 1'b0;
  end

  assign busy_o        = (st_q != ST_IDLE);
  assign done_o        = done_q;
  assign err_noresp_o  = enr_q;
  assign err_timeout_o = eto_q;
  assign recal_o       = recal_q;

  p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_noresp_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_noresp_o) |-> !busy_o && !done_o);

  p_tmo_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RISE) |-> (tcnt_q < TW'(DONE_TMO)));

  p_busy_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_i && !abort_o) |=> busy_o);
endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl #(
  parameter int MIN_W    = 4,
  parameter int MAX_W    = 1024,
  parameter int RESP_WIN = 8,
  parameter int DONE_TMO = 20000,
  parameter int SYNC_ST  = 2,
  localparam int WW = $clog2(MAX_W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cal_req_i,
  input  logic [WW-1:0] pulse_len_i,
  input  logic          eoc_ready_i,
  input  logic          drift_i,
  output logic          cal_start_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_noresp_o,
  output logic          err_timeout_o,
  output logic          recal_o,
  output logic          capture_en_o
);
  logic rdy_s, load, abort;

  cal_sync #(.STAGES(SYNC_ST), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (eoc_ready_i),
    .q_o   (rdy_s)
  );

  cal_fsm #(.RESP_WIN(RESP_WIN), .DONE_TMO(DONE_TMO)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (cal_req_i),
    .rdy_s_i      (rdy_s),
    .drift_i      (drift_i),
    .load_o       (load),
    .abort_o      (abort),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_noresp_o (err_noresp_o),
    .err_timeout_o(err_timeout_o),
    .recal_o      (recal_o)
  );

  cal_pulse_gen #(.MIN_W(MIN_W), .MAX_W(MAX_W)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .abort_i(abort),
    .len_i  (pulse_len_i),
    .pulse_o(cal_start_o)
  );

  assign capture_en_o = !busy_o;

  p_start_in_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_start_o |-> busy_o);

  p_recal_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drift_i |=> recal_o);
endmodule

// File: tb/tb_cal_seq_ctrl.sv
`timescale 1ns/1ps
module tb_cal_seq_ctrl;
  localparam int NV = 8;
  localparam int NEVER = 0;
  localparam int NOFALL = 255;
  localparam int RS_DONE = 0, RS_NR = 1, RS_TO = 2;

  localparam int VW [NV] = '{4,  1,  2000, 37, 4,  4,  100,    12};
  localparam int VF [NV] = '{1,  1,  2,    0,  5,  6,  NOFALL, 1};
  localparam int VR [NV] = '{40, 40, 1500, 90, 30, 30, 20,     NEVER};
  localparam int VQ [NV] = '{0,  0,  0,    1,  0,  0,  0,      0};
  localparam int VE [NV] = '{4,  4,  1024, 37, 4,  4,  8,      12};
  localparam int VX [NV] = '{RS_DONE, RS_DONE, RS_DONE, RS_DONE,
                             RS_DONE, RS_NR, RS_NR, RS_TO};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, line = 1'b1, drift = 1'b0;
  logic [10:0] len = '0;
  logic start, busy, done, enr, eto, recal, cap;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cal_seq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .cal_req_i(req), .pulse_len_i(len),
    .eoc_ready_i(line), .drift_i(drift), .cal_start_o(start), .busy_o(busy),
    .done_o(done), .err_noresp_o(enr), .err_timeout_o(eto), .recal_o(recal),
    .capture_en_o(cap)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int i);
    int hi = 0, dn = 0, badcap = 0, cnt = 0;
    @(negedge clk);
    req = 1'b1;
    len = 11'(VW[i]);
    @(negedge clk);
    req = 1'b0;
    while (cnt < 25000) begin
      if (start) hi++;
      if (done) dn++;
      if (busy == cap) badcap++;
      if (cnt > 0 && !busy) break;
      if (VF[i] != NOFALL && cnt == VF[i]) line = 1'b0;
      if (VR[i] != NEVER && cnt == VR[i]) line = 1'b1;
      req = (VQ[i] != 0 && cnt == 3);
      if (req) len = 11'd4;
      cnt++;
      @(negedge clk);
    end
    req = 1'b0;
    line = 1'b1;
    check(hi == VE[i], $sformatf("R2/R4 pulse width vec%0d", i), hi, VE[i]);
    check(badcap == 0, $sformatf("R9 capture gate vec%0d", i), badcap, 0);
    case (VX[i])
      RS_DONE: begin
        check(dn == 1, $sformatf("R5 done count vec%0d", i), dn, 1);
        check(!enr && !eto, $sformatf("R3/R7 no error vec%0d", i), {enr, eto}, 0);
      end
      RS_NR: begin
        check(enr == 1'b1 && dn == 0, $sformatf("R3/R4 noresp vec%0d", i), enr, 1);
      end
      default: begin
        check(eto == 1'b1 && dn == 0, $sformatf("R6 timeout vec%0d", i), eto, 1);
      end
    endcase
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({start, busy, done, enr, eto, recal} == 6'b0 && cap, "R1 reset outputs",
          {start, busy, done, enr, eto, recal, cap}, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 drift sets the flag
    drift = 1'b1;
    @(negedge clk);
    drift = 1'b0;
    check(recal == 1'b1, "R10 recal set", recal, 1);

    for (int i = 0; i < NV; i++) begin
      run_vec(i);
      if (i == 0) check(recal == 1'b0, "R10 recal cleared by done", recal, 0);
      if (i == 5) check(enr == 1'b1, "R7 noresp held", enr, 1);
    end

    // R7: the next accepted request clears the sticky timeout flag
    check(eto == 1'b1, "R7 timeout held", eto, 1);
    @(negedge clk);
    req = 1'b1;
    len = 11'd4;
    @(negedge clk);
    req = 1'b0;
    check(eto == 1'b0 && busy, "R7 flags cleared on request", eto, 0);
    line = 1'b0;
    repeat (10) @(negedge clk);
    line = 1'b1;
    repeat (6) @(negedge clk);
    check(!busy && cap, "R9 idle after completion", busy, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule